// File: doc/BRIEF.md
# Software Flow-Control Character Filter

This block sits between the character output of a UART receiver and the write port of its receive FIFO. Every received character is compared against four host-programmable control characters: two resume characters and two stop characters. In single mode one character makes a match. In double mode two consecutive characters must match the first and the second character of a pair. A matched stop pattern raises a pause request toward the transmitter and sets a stop flag that can raise an interrupt. A matched resume pattern drops the pause and clears the flag. Characters consumed by a match never reach the FIFO. All other characters are forwarded one cycle after they arrive.

The pause request reaches the transmitter through a hold output. The hold output only rises while the transmitter reports no frame in progress, so a frame that has already started always completes. A second function watches the receive FIFO fill level. When the level reaches the upper threshold, the block asks the transmitter to send the stop pair. Once the level has drained to the lower threshold, it asks for the resume pair.

The receiver must leave at least one idle cycle between characters (`rx_valid` is never high on two consecutive cycles). The block uses that gap to re-examine a character after a broken double-mode pair.

Top module: `swfc_top`

## Requirements
- R1: After reset, `pause_req`, `tx_hold`, `xoff_flag`, `irq`, `fifo_wr` and `ctl_req` are low, and all four control characters read as 0x00. A received 0x00 is therefore treated as a stop character.
- R2: In single mode, a character that matches no control character appears on `fifo_data` with `fifo_wr` high exactly one cycle after it is received.
- R3: A stop match (single: the stop-1 character; double: stop-1 followed by stop-2) sets `pause_req` and `xoff_flag` on the next cycle, and writes nothing to the FIFO.
- R4: While paused, a resume match (single: resume-1; double: resume-1 followed by resume-2) clears `pause_req` and `xoff_flag`. A resume match while not paused is consumed and has no other effect.
- R5: `tx_hold` rises only on the cycle after `pause_req` is high while `tx_busy` is low. It falls one cycle after `pause_req` falls.
- R6: `irq` is high exactly when `xoff_flag` and `irq_en` are both high. An `irq_ack` pulse clears `xoff_flag`. When a stop match and `irq_ack` land in the same cycle, the flag ends up set.
- R7: In double mode, neither character of a matched pair is written to the FIFO.
- R8: In double mode, when a first character matches but the next one does not complete the pair, the first character is written to the FIFO one cycle after the second arrives. The second character is then re-examined from scratch on the following cycle.
- R9: A host write with `cfg_we` high stores `cfg_wdata` into the character chosen by `cfg_sel`: 0 resume-1, 1 resume-2, 2 stop-1, 3 stop-2. The new value governs every later comparison.
- R10: When `fifo_level` >= `lvl_hi` and no automatic stop is outstanding, `ctl_req` rises with stop-1 on `ctl_data`. A `ctl_take` pulse advances it to stop-2, and a second pulse drops `ctl_req`. `ctl_data` is stable while `ctl_req` waits for `ctl_take`.
- R11: After an automatic stop has been sent, no further stop is requested while the level stays above `lvl_lo`. Once `fifo_level` <= `lvl_lo`, resume-1 and then resume-2 are requested, with the same handshake as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Host write strobe for a control character |
| cfg_sel | input | 2 | Selects the control character to write |
| cfg_wdata | input | 8 | Control character value |
| mode_double | input | 1 | 1: two-character patterns, 0: single-character |
| irq_en | input | 1 | Enables the stop-flag interrupt |
| irq_ack | input | 1 | Host read of interrupt identity, clears the stop flag |
| rx_valid | input | 1 | Received character strobe |
| rx_data | input | 8 | Received character |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Character written to the receive FIFO |
| fifo_level | input | LVL_W | Current receive FIFO fill level |
| lvl_hi | input | LVL_W | Upper threshold for the automatic stop |
| lvl_lo | input | LVL_W | Lower threshold for the automatic resume |
| tx_busy | input | 1 | Transmitter is in the middle of a frame |
| tx_hold | output | 1 | Transmitter must not start a new data frame |
| pause_req | output | 1 | Stop pattern received and not yet resumed |
| ctl_req | output | 1 | Request to transmit a control character |
| ctl_data | output | 8 | Control character to transmit |
| ctl_take | input | 1 | Transmitter accepted `ctl_data` |
| xoff_flag | output | 1 | Stop flag for the interrupt identity |
| irq | output | 1 | Interrupt request |

## Verification
The stop-flag path has two functions that can act in the same cycle: a stop match that sets the flag, and a host acknowledge that clears it. The bench provokes this by driving a stop character and `irq_ack` at the same clock edge. It then expects the flag and `irq` to read high one cycle later. A separate acknowledge alone must then clear the flag. A broken double-mode pair also produces a FIFO write and a fresh match attempt on back-to-back cycles. This is judged from the order and timing of the writes and from the pause state after the following character.

// File: rtl/swfc_pkg.sv
package swfc_pkg;
    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        char_t xon1;
        char_t xon2;
        char_t xoff1;
        char_t xoff2;
    } fc_chars_t;

    typedef enum logic [1:0] {
        SEL_XON1  = 2'd0,
        SEL_XON2  = 2'd1,
        SEL_XOFF1 = 2'd2,
        SEL_XOFF2 = 2'd3
    } fc_sel_e;

    typedef enum logic [2:0] {
        AF_IDLE,
        AF_OFF1,
        AF_OFF2,
        AF_ON1,
        AF_ON2
    } af_state_e;

    typedef struct packed {
        logic resume;
        logic pause;
    } fc_event_t;

    function automatic fc_chars_t char_write(fc_chars_t cur, logic [1:0] sel, char_t d);
        fc_chars_t nxt = cur;
        case (fc_sel_e'(sel))
            SEL_XON1:  nxt.xon1  = d;
            SEL_XON2:  nxt.xon2  = d;
            SEL_XOFF1: nxt.xoff1 = d;
            default:   nxt.xoff2 = d;
        endcase
        return nxt;
    endfunction
endpackage

// File: rtl/swfc_matcher.sv
module swfc_matcher
    import swfc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  fc_chars_t chars,
    input  logic      mode_double,
    input  logic      paused,
    input  logic      rx_valid,
    input  char_t     rx_data,
    output fc_event_t ev,
    output logic      fifo_wr,
    output char_t     fifo_data
);
    // pending first character of a double pattern
    logic  pend_v, pend_on, pend_off;
    char_t pend_c;
    // character to re-examine after a broken pair
    logic  rep_v;
    char_t rep_c;

    logic  pend_v_n, pend_on_n, pend_off_n, rep_v_n, wr_n;
    char_t pend_c_n, rep_c_n, data_n;

    logic  in_v, on_m, off_m, pair_on, pair_off;
    char_t in_c;

    always_comb begin
        in_v     = rx_valid | rep_v;
        in_c     = rx_valid ? rx_data : rep_c;
        on_m     = (in_c == chars.xon1);
        off_m    = (in_c == chars.xoff1);
        pair_on  = pend_on  && (in_c == chars.xon2);
        pair_off = pend_off && (in_c == chars.xoff2);

        ev         = '0;
        wr_n       = 1'b0;
        data_n     = in_c;
        pend_v_n   = pend_v;
        pend_c_n   = pend_c;
        pend_on_n  = pend_on;
        pend_off_n = pend_off;
        rep_v_n    = 1'b0;
        rep_c_n    = rep_c;

        if (in_v) begin
            if (!mode_double) begin
                pend_v_n = 1'b0;
                if (paused && on_m)  ev.resume = 1'b1;
                else if (off_m)      ev.pause  = 1'b1;
                else if (!on_m)      wr_n      = 1'b1;
            end else if (!pend_v) begin
                if (on_m || off_m) begin
                    pend_v_n   = 1'b1;
                    pend_c_n   = in_c;
                    pend_on_n  = on_m;
                    pend_off_n = off_m;
                end else begin
                    wr_n = 1'b1;
                end
            end else begin
                pend_v_n = 1'b0;
                if (paused && pair_on) ev.resume = 1'b1;
                else if (pair_off)     ev.pause  = 1'b1;
                else if (!pair_on) begin
                    wr_n    = 1'b1;
                    data_n  = pend_c;
                    rep_v_n = 1'b1;
                    rep_c_n = in_c;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v    <= 1'b0;
            pend_on   <= 1'b0;
            pend_off  <= 1'b0;
            pend_c    <= '0;
            rep_v     <= 1'b0;
            rep_c     <= '0;
            fifo_wr   <= 1'b0;
            fifo_data <= '0;
        end else begin
            pend_v    <= pend_v_n;
            pend_on   <= pend_on_n;
            pend_off  <= pend_off_n;
            pend_c    <= pend_c_n;
            rep_v     <= rep_v_n;
            rep_c     <= rep_c_n;
            fifo_wr   <= wr_n;
            fifo_data <= data_n;
        end
    end
endmodule

// File: rtl/swfc_autoflow.sv
module swfc_autoflow
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  fc_chars_t        chars,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] lvl_hi,
    input  logic [LVL_W-1:0] lvl_lo,
    input  logic             ctl_take,
    output logic             ctl_req,
    output char_t            ctl_data
);
    af_state_e st;
    logic      sent;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= AF_IDLE;
            sent     <= 1'b0;
            ctl_data <= '0;
        end else begin
            case (st)
                AF_IDLE: begin
                    if (!sent && fifo_level >= lvl_hi) begin
                        st       <= AF_OFF1;
                        sent     <= 1'b1;
                        ctl_data <= chars.xoff1;
                    end else if (sent && fifo_level <= lvl_lo) begin
                        st       <= AF_ON1;
                        sent     <= 1'b0;
                        ctl_data <= chars.xon1;
                    end
                end
                AF_OFF1: if (ctl_take) begin
                    st       <= AF_OFF2;
                    ctl_data <= chars.xoff2;
                end
                AF_ON1: if (ctl_take) begin
                    st       <= AF_ON2;
                    ctl_data <= chars.xon2;
                end
                default: if (ctl_take) st <= AF_IDLE;
            endcase
        end
    end

    assign ctl_req = (st != AF_IDLE);
endmodule

// File: rtl/swfc_top.sv
module swfc_top
    import swfc_pkg::*;
#(
    parameter int LVL_W = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_sel,
    input  logic [7:0]       cfg_wdata,
    input  logic             mode_double,
    input  logic             irq_en,
    input  logic             irq_ack,
    input  logic             rx_valid,
    input  logic [7:0]       rx_data,
    output logic             fifo_wr,
    output logic [7:0]       fifo_data,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic [LVL_W-1:0] lvl_hi,
    input  logic [LVL_W-1:0] lvl_lo,
    input  logic             tx_busy,
    output logic             tx_hold,
    output logic             pause_req,
    output logic             ctl_req,
    output logic [7:0]       ctl_data,
    input  logic             ctl_take,
    output logic             xoff_flag,
    output logic             irq
);
    fc_chars_t chars;
    fc_event_t ev;

    always_ff @(posedge clk) begin
        if (rst)         chars <= '0;
        else if (cfg_we) chars <= char_write(chars, cfg_sel, cfg_wdata);
    end

    swfc_matcher u_match (
        .clk        (clk),
        .rst        (rst),
        .chars      (chars),
        .mode_double(mode_double),
        .paused     (pause_req),
        .rx_valid   (rx_valid),
        .rx_data    (rx_data),
        .ev         (ev),
        .fifo_wr    (fifo_wr),
        .fifo_data  (fifo_data)
    );

    swfc_autoflow #(.LVL_W(LVL_W)) u_auto (
        .clk       (clk),
        .rst       (rst),
        .chars     (chars),
        .fifo_level(fifo_level),
        .lvl_hi    (lvl_hi),
        .lvl_lo    (lvl_lo),
        .ctl_take  (ctl_take),
        .ctl_req   (ctl_req),
        .ctl_data  (ctl_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pause_req <= 1'b0;
            xoff_flag <= 1'b0;
            tx_hold   <= 1'b0;
        end else begin
            if (ev.resume)     pause_req <= 1'b0;
            else if (ev.pause) pause_req <= 1'b1;

            if (ev.pause)                    xoff_flag <= 1'b1;
            else if (ev.resume || irq_ack)   xoff_flag <= 1'b0;

            // hold only engages between frames, then stays until release
            tx_hold <= pause_req && (tx_hold || !tx_busy);
        end
    end

    assign irq = xoff_flag & irq_en;
endmodule

// File: rtl/swfc_chk.sv
module swfc_chk (
    input logic       clk,
    input logic       rst,
    input logic       rx_valid,
    input logic       irq_ack,
    input logic       tx_busy,
    input logic       tx_hold,
    input logic       pause_req,
    input logic       xoff_flag,
    input logic       ctl_req,
    input logic       ctl_take,
    input logic [7:0] ctl_data
);
    // R3
    pause_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pause_req) |-> xoff_flag);

    // R4
    resume_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pause_req) |-> !xoff_flag);

    // R5
    hold_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_hold) |-> $past(pause_req && !tx_busy));

    // R5
    hold_release_chk: assert property (@(posedge clk) disable iff (rst)
        !pause_req |=> !tx_hold);

    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(xoff_flag) |-> ($past(irq_ack) || $fell(pause_req)));

    // R10
    ctl_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ctl_req && !ctl_take) |=> (ctl_req && $stable(ctl_data)));

    // R8 relies on an idle cycle between received characters
    rx_gap_chk: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid);
endmodule

bind swfc_top swfc_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rx_valid (rx_valid),
    .irq_ack  (irq_ack),
    .tx_busy  (tx_busy),
    .tx_hold  (tx_hold),
    .pause_req(pause_req),
    .xoff_flag(xoff_flag),
    .ctl_req  (ctl_req),
    .ctl_take (ctl_take),
    .ctl_data (ctl_data)
);

// File: tb/tb_swfc_top.sv
`timescale 1ns/1ps
module tb_swfc_top;
    localparam int LVL_W = 7;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0;
    logic [1:0] cfg_sel = 0;
    logic [7:0] cfg_wdata = 0;
    logic mode_double = 0, irq_en = 0, irq_ack = 0;
    logic rx_valid = 0;
    logic [7:0] rx_data = 0;
    logic fifo_wr;
    logic [7:0] fifo_data;
    logic [LVL_W-1:0] fifo_level = 0, lvl_hi = 8, lvl_lo = 2;
    logic tx_busy = 0, tx_hold, pause_req, ctl_req, ctl_take = 0, xoff_flag, irq;
    logic [7:0] ctl_data;

    int errors = 0;
    int checks = 0;
    logic done = 0;

    always #4 clk = ~clk;

    swfc_top #(.LVL_W(LVL_W)) dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .mode_double(mode_double), .irq_en(irq_en), .irq_ack(irq_ack),
        .rx_valid(rx_valid), .rx_data(rx_data), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
        .fifo_level(fifo_level), .lvl_hi(lvl_hi), .lvl_lo(lvl_lo),
        .tx_busy(tx_busy), .tx_hold(tx_hold), .pause_req(pause_req),
        .ctl_req(ctl_req), .ctl_data(ctl_data), .ctl_take(ctl_take),
        .xoff_flag(xoff_flag), .irq(irq)
    );

    typedef struct packed {
        logic       dbl;
        logic [7:0] ch;
        logic       w1;
        logic [7:0] d1;
        logic       w2;
        logic [7:0] d2;
        logic       pz;
    } vec_t;

    // characters: resume 0x11/0x12, stop 0x13/0x14
    localparam vec_t VEC [16] = '{
        '{1'b0, 8'h41, 1'b1, 8'h41, 1'b0, 8'h00, 1'b0},  // R2
        '{1'b0, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},  // R3
        '{1'b0, 8'h42, 1'b1, 8'h42, 1'b0, 8'h00, 1'b1},  // R2 while paused
        '{1'b0, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R4
        '{1'b0, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R4 not paused
        '{1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R7 first half
        '{1'b1, 8'h14, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},  // R7 stop pair
        '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        '{1'b1, 8'h55, 1'b1, 8'h11, 1'b1, 8'h55, 1'b1},  // R8 broken pair
        '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        '{1'b1, 8'h12, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},  // R7 resume pair
        '{1'b1, 8'h13, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0},
        '{1'b1, 8'h13, 1'b1, 8'h13, 1'b0, 8'h00, 1'b0},  // R8 replay re-pends
        '{1'b1, 8'h14, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},  // R8 pair from replay
        '{1'b1, 8'h11, 1'b0, 8'h00, 1'b0, 8'h00, 1'b1},
        '{1'b1, 8'h12, 1'b0, 8'h00, 1'b0, 8'h00, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic send(input logic [7:0] c, output logic w1, output logic [7:0] d1,
                        output logic w2, output logic [7:0] d2);
        rx_valid = 1'b1;
        rx_data  = c;
        @(negedge clk);
        rx_valid = 1'b0;
        w1 = fifo_wr;
        d1 = fifo_data;
        @(negedge clk);
        w2 = fifo_wr;
        d2 = fifo_data;
    endtask

    task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic take();
        ctl_take = 1'b1;
        @(negedge clk);
        ctl_take = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic w1, w2;
        logic [7:0] d1, d2;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 pause", pause_req, 0);
        check("R1 hold", tx_hold, 0);
        check("R1 flag", xoff_flag, 0);
        check("R1 irq", irq, 0);
        check("R1 fifo_wr", fifo_wr, 0);
        check("R1 ctl_req", ctl_req, 0);
        // R1 characters reset to zero: 0x00 stops, then resumes
        send(8'h00, w1, d1, w2, d2);
        check("R1 zero consumed", w1, 0);
        check("R1 zero stops", pause_req, 1);
        send(8'h00, w1, d1, w2, d2);
        check("R1 zero resumes", pause_req, 0);

        // R9 programming
        cfg(2'd0, 8'h11);
        cfg(2'd1, 8'h12);
        cfg(2'd2, 8'h13);
        cfg(2'd3, 8'h14);
        send(8'h00, w1, d1, w2, d2);
        check("R9 old value forwarded", w1, 1);
        check("R9 old value data", d1, 8'h00);

        // vector table
        for (int i = 0; i < 16; i++) begin
            mode_double = VEC[i].dbl;
            send(VEC[i].ch, w1, d1, w2, d2);
            check($sformatf("R2/R7/R8 vec%0d wr1", i), w1, VEC[i].w1);
            if (VEC[i].w1) check($sformatf("R2/R8 vec%0d d1", i), d1, VEC[i].d1);
            check($sformatf("R8 vec%0d wr2", i), w2, VEC[i].w2);
            if (VEC[i].w2) check($sformatf("R8 vec%0d d2", i), d2, VEC[i].d2);
            check($sformatf("R3/R4 vec%0d pause", i), pause_req, VEC[i].pz);
        end
        mode_double = 1'b0;

        // R9 rewrite stop-1
        cfg(2'd2, 8'h20);
        send(8'h13, w1, d1, w2, d2);
        check("R9 stale stop forwarded", w1, 1);
        check("R9 stale stop no pause", pause_req, 0);
        send(8'h20, w1, d1, w2, d2);
        check("R9 new stop pauses", pause_req, 1);
        send(8'h11, w1, d1, w2, d2);
        check("R9 resume", pause_req, 0);
        cfg(2'd2, 8'h13);

        // R6 irq gating and acknowledge
        irq_en = 1'b0;
        send(8'h13, w1, d1, w2, d2);
        check("R6 flag set", xoff_flag, 1);
        check("R6 irq masked", irq, 0);
        irq_en = 1'b1;
        #1;
        check("R6 irq enabled", irq, 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R6 ack clears flag", xoff_flag, 0);
        check("R6 ack clears irq", irq, 0);
        check("R6 ack keeps pause", pause_req, 1);
        send(8'h11, w1, d1, w2, d2);
        check("R4 resumed", pause_req, 0);

        // R6 set and acknowledge in the same cycle
        rx_valid = 1'b1; rx_data = 8'h13; irq_ack = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; irq_ack = 1'b0;
        check("R6 collision flag", xoff_flag, 1);
        check("R6 collision irq", irq, 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check("R6 later ack", xoff_flag, 0);
        send(8'h11, w1, d1, w2, d2);
        check("R4 flag after resume", xoff_flag, 0);

        // R5 hold waits for the frame in progress
        tx_busy = 1'b1;
        send(8'h13, w1, d1, w2, d2);
        check("R5 paused", pause_req, 1);
        check("R5 hold waits", tx_hold, 0);
        @(negedge clk);
        check("R5 hold still waits", tx_hold, 0);
        tx_busy = 1'b0;
        @(negedge clk);
        check("R5 hold engages", tx_hold, 1);
        tx_busy = 1'b1;
        @(negedge clk);
        check("R5 hold sticks", tx_hold, 1);
        tx_busy = 1'b0;
        send(8'h11, w1, d1, w2, d2);
        check("R5 hold released", tx_hold, 0);

        // R10 automatic stop
        fifo_level = 8;
        @(negedge clk);
        check("R10 req", ctl_req, 1);
        check("R10 stop1", ctl_data, 8'h13);
        @(negedge clk);
        check("R10 waits", ctl_data, 8'h13);
        take();
        check("R10 stop2 req", ctl_req, 1);
        check("R10 stop2", ctl_data, 8'h14);
        take();
        check("R10 done", ctl_req, 0);
        repeat (3) @(negedge clk);
        check("R11 no repeat at high", ctl_req, 0);
        fifo_level = 5;
        repeat (2) @(negedge clk);
        check("R11 no action mid", ctl_req, 0);
        // R11 automatic resume
        fifo_level = 2;
        @(negedge clk);
        check("R11 req", ctl_req, 1);
        check("R11 resume1", ctl_data, 8'h11);
        take();
        check("R11 resume2", ctl_data, 8'h12);
        take();
        check("R11 done", ctl_req, 0);
        repeat (2) @(negedge clk);
        check("R11 idle", ctl_req, 0);

        finish_run();
    end
endmodule